// File: doc/BRIEF.md
# Serial Receiver Wakeup Event Detector

This block watches the receive side of a serial port while the chip sleeps and raises a sticky wakeup flag when a chosen event happens. Three events can wake the chip: a received byte that carries the programmed node address, the start of a new character on the line, or any completed byte becoming ready.

A two-bit source selector picks the event. The address comparison covers either the low seven bits or the low four bits of the byte, set by a width bit. A confirmed start bit is a falling edge on the raw line, taken through a two-flop synchronizer and still low at mid-bit. The flag can only set while the low-power input is high. It holds until a clear strobe arrives. It can also raise a single-cycle interrupt when it sets.

All configuration is written through a small write port, and that port is locked while the serial unit is enabled.

Top module: `rx_wake_detect`

## Requirements
- R1: After reset `wakeFlag` and `wakeIrq` are 0. The reset configuration is source code 00, address 0x00, 4-bit compare and interrupt disabled.
- R2: With source code 00 and `cfgAddrWide`=1, a `byteDone` strobe whose byte matches the programmed address in bits 6:0 sets `wakeFlag` two rising edges after the strobe is sampled. A byte that differs in bits 6:0 does not set the flag.
- R3: With source code 00 and `cfgAddrWide`=0, only bits 3:0 are compared. A byte that differs from the address only in bits 7:4 still sets the flag.
- R4: With source code 10, a falling edge on `rxLine` that is still low half a bit time (`BIT_CYCLES`/2 clocks) after it is synchronized sets the flag. A low pulse shorter than that does not.
- R5: With source code 11, every `byteDone` strobe sets the flag, whatever the byte value.
- R6: Source code 01 is reserved. With it selected, no event ever sets the flag.
- R7: A configuration write while `unitEnable`=1 is ignored. The source, address, compare width and interrupt enable all keep their previous values.
- R8: The flag sets only when `lowPower` is 1 in the cycle the selected event is seen.
- R9: Once set, the flag holds until `wakeClear` is pulsed. If a new qualified event arrives in the same cycle as the clear, the flag stays set.
- R10: `wakeIrq` is high for exactly the one cycle in which `wakeFlag` rises, and only when the interrupt enable is configured to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Raw asynchronous receive line, idle high |
| byteDone | input | 1 | One-cycle strobe: a received byte is complete |
| rxByte | input | 8 | Received byte, valid with `byteDone` |
| unitEnable | input | 1 | Serial unit enabled; locks the configuration |
| lowPower | input | 1 | Device is in low-power mode |
| wakeClear | input | 1 | One-cycle strobe that clears the wakeup flag |
| cfgWrite | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Source: 00 address, 01 reserved, 10 start bit, 11 data ready |
| cfgAddr | input | 8 | Node address to match |
| cfgAddrWide | input | 1 | 1: compare bits 6:0; 0: compare bits 3:0 |
| cfgIrqEn | input | 1 | Interrupt enable |
| wakeFlag | output | 1 | Sticky wakeup flag |
| wakeIrq | output | 1 | One-cycle wakeup interrupt pulse |

## Verification
The bench targets the compare width. It sends bytes that differ from the address only in the upper nibble or only in bit 7. A design that masks wrongly either misses a wakeup or wakes on a foreign address. It sends a low pulse shorter than half a bit, which a design without mid-bit confirmation would take as a start. It writes a new source while the unit is enabled, then shows that the old source still governs. It lines up an event with the clear strobe in the same cycle: a design that gives the clear priority drops the wakeup. The bench also checks that the reserved code and an idle `lowPower` never set the flag, and that the interrupt fires once and only when enabled.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'b00,
    SEL_RSVD  = 2'b01,
    SEL_START = 2'b10,
    SEL_DATA  = 2'b11
  } wakeSel_e;

  // Event strobes from the datapath to the control, one cycle each
  typedef struct packed {
    logic addrHit;
    logic startSeen;
    logic dataReady;
  } evtStrobes_t;

endpackage

// File: rtl/rxw_datapath.sv
module rxw_datapath #(
  parameter int DATA_W      = 8,
  parameter int BIT_CYCLES  = 16,
  parameter int SYNC_STAGES = 2,
  parameter int WIDE_BITS   = 7,
  parameter int NARROW_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] addrReg,
  input  logic              addrWide,
  output rxw_pkg::evtStrobes_t evt
);
  localparam int HALF  = (BIT_CYCLES / 2 < 2) ? 2 : BIT_CYCLES / 2;
  localparam int CNT_W = $clog2(HALF);
  localparam logic [DATA_W-1:0] MASK_WIDE   = {{(DATA_W-WIDE_BITS){1'b0}}, {WIDE_BITS{1'b1}}};
  localparam logic [DATA_W-1:0] MASK_NARROW = {{(DATA_W-NARROW_BITS){1'b0}}, {NARROW_BITS{1'b1}}};

  // Synchronizer chain, reset to line idle level
  logic [SYNC_STAGES-1:0] syncQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b1;
    else       syncQ[0] <= rxLine;
  end
  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[g] <= 1'b1;
      else       syncQ[g] <= syncQ[g-1];
    end
  end

  logic rxSync;
  logic rxPrev;
  logic fallEdge;
  assign rxSync   = syncQ[SYNC_STAGES-1];
  assign fallEdge = rxPrev & ~rxSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxPrev <= 1'b1;
    else       rxPrev <= rxSync;
  end

  // Mid-bit confirmation of a start bit
  logic             hunting;
  logic [CNT_W-1:0] huntCnt;
  logic             startSeenQ;
  logic             midPoint;
  assign midPoint = hunting && (huntCnt == CNT_W'(HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hunting    <= 1'b0;
      huntCnt    <= '0;
      startSeenQ <= 1'b0;
    end else begin
      startSeenQ <= 1'b0;
      if (!hunting) begin
        if (fallEdge) begin
          hunting <= 1'b1;
          huntCnt <= '0;
        end
      end else if (midPoint) begin
        hunting    <= 1'b0;
        startSeenQ <= ~rxSync;
      end else begin
        huntCnt <= huntCnt + 1'b1;
      end
    end
  end

  // Address compare on completed bytes
  logic [DATA_W-1:0] cmpMask;
  logic              addrEq;
  logic              addrHitQ;
  logic              dataReadyQ;
  assign cmpMask = addrWide ? MASK_WIDE : MASK_NARROW;
  assign addrEq  = ((rxByte & cmpMask) == (addrReg & cmpMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHitQ   <= 1'b0;
      dataReadyQ <= 1'b0;
    end else begin
      addrHitQ   <= byteDone & addrEq;
      dataReadyQ <= byteDone;
    end
  end

  assign evt.addrHit   = addrHitQ;
  assign evt.startSeen = startSeenQ;
  assign evt.dataReady = dataReadyQ;

  // A confirmed start is only reported after a synchronized low level
  AST_START_AFTER_LOW: assert property (@(posedge clk) disable iff (!rstN)
    startSeenQ |-> !$past(rxSync)); // R4
  // Every address hit is backed by a completed byte one cycle earlier
  AST_HIT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    addrHitQ |-> $past(byteDone)); // R2
endmodule

// File: rtl/rxw_control.sv
module rxw_control #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              unitEnable,
  input  logic              lowPower,
  input  logic              wakeClear,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgAddr,
  input  logic              cfgAddrWide,
  input  logic              cfgIrqEn,
  input  rxw_pkg::evtStrobes_t evt,
  output logic [DATA_W-1:0] addrReg,
  output logic              addrWide,
  output logic              wakeFlag,
  output logic              wakeIrq
);
  import rxw_pkg::*;

  wakeSel_e selReg;
  logic     irqEnReg;
  logic     cfgTake;
  assign cfgTake = cfgWrite & ~unitEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg   <= SEL_ADDR;
      addrReg  <= '0;
      addrWide <= 1'b0;
      irqEnReg <= 1'b0;
    end else if (cfgTake) begin
      selReg   <= wakeSel_e'(cfgSel);
      addrReg  <= cfgAddr;
      addrWide <= cfgAddrWide;
      irqEnReg <= cfgIrqEn;
    end
  end

  logic evtPick;
  always_comb begin
    unique case (selReg)
      SEL_ADDR:  evtPick = evt.addrHit;
      SEL_START: evtPick = evt.startSeen;
      SEL_DATA:  evtPick = evt.dataReady;
      default:   evtPick = 1'b0;
    endcase
  end

  logic setNow;
  assign setNow = evtPick & lowPower;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeFlag <= 1'b0;
      wakeIrq  <= 1'b0;
    end else begin
      wakeIrq <= setNow & ~wakeFlag & irqEnReg;
      if (setNow)         wakeFlag <= 1'b1;
      else if (wakeClear) wakeFlag <= 1'b0;
    end
  end

  AST_FLAG_NEEDS_LP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeFlag) |-> $past(lowPower)); // R8
  AST_RESERVED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (selReg == SEL_RSVD && !wakeFlag) |=> !wakeFlag); // R6
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    unitEnable |=> ($stable(selReg) && $stable(addrReg) && $stable(irqEnReg))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wakeFlag && !wakeClear) |=> wakeFlag); // R9
  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> ($rose(wakeFlag) && $past(irqEnReg))); // R10
endmodule

// File: rtl/rx_wake_detect.sv
module rx_wake_detect #(
  parameter int DATA_W      = 8,
  parameter int BIT_CYCLES  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              byteDone,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              unitEnable,
  input  logic              lowPower,
  input  logic              wakeClear,
  input  logic              cfgWrite,
  input  logic [1:0]        cfgSel,
  input  logic [DATA_W-1:0] cfgAddr,
  input  logic              cfgAddrWide,
  input  logic              cfgIrqEn,
  output logic              wakeFlag,
  output logic              wakeIrq
);
  rxw_pkg::evtStrobes_t evt;
  logic [DATA_W-1:0]    addrReg;
  logic                 addrWide;

  rxw_datapath #(
    .DATA_W(DATA_W), .BIT_CYCLES(BIT_CYCLES), .SYNC_STAGES(SYNC_STAGES),
    .WIDE_BITS(7), .NARROW_BITS(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .byteDone(byteDone),
    .rxByte(rxByte), .addrReg(addrReg), .addrWide(addrWide), .evt(evt)
  );

  rxw_control #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rstN(rstN), .unitEnable(unitEnable), .lowPower(lowPower),
    .wakeClear(wakeClear), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
    .cfgAddr(cfgAddr), .cfgAddrWide(cfgAddrWide), .cfgIrqEn(cfgIrqEn),
    .evt(evt), .addrReg(addrReg), .addrWide(addrWide),
    .wakeFlag(wakeFlag), .wakeIrq(wakeIrq)
  );
endmodule

// File: tb/rx_wake_detect_tb.sv
module rx_wake_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BITC = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxLine = 1'b1, byteDone = 1'b0, unitEnable = 1'b0, lowPower = 1'b1;
  logic wakeClear = 1'b0, cfgWrite = 1'b0, cfgAddrWide = 1'b0, cfgIrqEn = 1'b0;
  logic [1:0] cfgSel = 2'b00;
  logic [7:0] rxByte = '0, cfgAddr = '0;
  logic wakeFlag, wakeIrq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_wake_detect #(.DATA_W(8), .BIT_CYCLES(BITC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .byteDone(byteDone), .rxByte(rxByte),
    .unitEnable(unitEnable), .lowPower(lowPower), .wakeClear(wakeClear),
    .cfgWrite(cfgWrite), .cfgSel(cfgSel), .cfgAddr(cfgAddr),
    .cfgAddrWide(cfgAddrWide), .cfgIrqEn(cfgIrqEn),
    .wakeFlag(wakeFlag), .wakeIrq(wakeIrq));

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] addr, input logic wide, input logic ien);
    @(negedge clk);
    cfgWrite = 1'b1; cfgSel = sel; cfgAddr = addr; cfgAddrWide = wide; cfgIrqEn = ien;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic clearFlag();
    @(negedge clk); wakeClear = 1'b1;
    @(negedge clk); wakeClear = 1'b0;
  endtask

  // Pulses byteDone and returns at the negedge where the flag is visible
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); byteDone = 1'b1; rxByte = b;
    @(negedge clk); byteDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic lowPulse(input int cyc);
    @(negedge clk); rxLine = 1'b0;
    repeat (cyc) @(negedge clk);
    rxLine = 1'b1;
    repeat (BITC + 6) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(wakeFlag, 1'b0, "R1", "flag after reset");
    check(wakeIrq, 1'b0, "R1", "irq after reset");
    sendByte(8'h30);   // reset config: code 00, addr 0, 4-bit: low nibble 0 matches
    check(wakeFlag, 1'b1, "R1", "reset config matches addr 0 low nibble");
    check(wakeIrq, 1'b0, "R1", "irq disabled at reset");
    clearFlag();
  endtask

  task automatic t_addr_wide();
    cfg(2'b00, 8'h5A, 1'b1, 1'b1);
    sendByte(8'h5B);
    check(wakeFlag, 1'b0, "R2", "mismatch in low bits");
    sendByte(8'hDA);
    check(wakeFlag, 1'b1, "R2", "match on bits 6:0 bit7 differs");
    check(wakeIrq, 1'b1, "R10", "irq on rise");
    @(negedge clk);
    check(wakeIrq, 1'b0, "R10", "irq one cycle");
    sendByte(8'h5A);
    check(wakeIrq, 1'b0, "R10", "no irq when already set");
    clearFlag();
    check(wakeFlag, 1'b0, "R9", "clear works");
    sendByte(8'h1A);
    check(wakeFlag, 1'b0, "R2", "bit6 differs in wide mode");
  endtask

  task automatic t_addr_narrow();
    cfg(2'b00, 8'h05, 1'b0, 1'b0);
    sendByte(8'hF5);
    check(wakeFlag, 1'b1, "R3", "upper nibble ignored");
    check(wakeIrq, 1'b0, "R10", "irq disabled");
    clearFlag();
    sendByte(8'h06);
    check(wakeFlag, 1'b0, "R3", "low nibble mismatch");
  endtask

  task automatic t_start();
    cfg(2'b10, 8'h00, 1'b1, 1'b1);
    lowPulse(3);
    check(wakeFlag, 1'b0, "R4", "short glitch ignored");
    lowPulse(BITC);
    check(wakeFlag, 1'b1, "R4", "confirmed start bit");
    clearFlag();
    sendByte(8'h00);
    check(wakeFlag, 1'b0, "R4", "bytes ignored in start mode");
  endtask

  task automatic t_data();
    cfg(2'b11, 8'h00, 1'b1, 1'b0);
    sendByte(8'hA7);
    check(wakeFlag, 1'b1, "R5", "any byte wakes");
    clearFlag();
    sendByte(8'h00);
    check(wakeFlag, 1'b1, "R5", "zero byte wakes");
    clearFlag();
  endtask

  task automatic t_reserved();
    cfg(2'b01, 8'h00, 1'b0, 1'b1);
    sendByte(8'h00);
    check(wakeFlag, 1'b0, "R6", "reserved, byte");
    lowPulse(BITC);
    check(wakeFlag, 1'b0, "R6", "reserved, start");
  endtask

  task automatic t_lock();
    cfg(2'b11, 8'h00, 1'b1, 1'b0);
    @(negedge clk); unitEnable = 1'b1;
    cfg(2'b01, 8'h00, 1'b1, 1'b1);
    sendByte(8'h44);
    check(wakeFlag, 1'b1, "R7", "locked write kept data source");
    check(wakeIrq, 1'b0, "R7", "locked write kept irq disabled");
    clearFlag();
    @(negedge clk); unitEnable = 1'b0;
  endtask

  task automatic t_lowpower();
    cfg(2'b11, 8'h00, 1'b1, 1'b0);
    @(negedge clk); lowPower = 1'b0;
    sendByte(8'h12);
    check(wakeFlag, 1'b0, "R8", "no wake outside low power");
    @(negedge clk); lowPower = 1'b1;
  endtask

  task automatic t_set_wins();
    sendByte(8'h01);
    check(wakeFlag, 1'b1, "R9", "flag set");
    repeat (4) @(negedge clk);
    check(wakeFlag, 1'b1, "R9", "flag sticky");
    @(negedge clk); byteDone = 1'b1;
    @(negedge clk); byteDone = 1'b0; wakeClear = 1'b1;
    @(negedge clk); wakeClear = 1'b0;
    check(wakeFlag, 1'b1, "R9", "event beats clear");
    clearFlag();
    check(wakeFlag, 1'b0, "R9", "cleared");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_addr_wide();
    t_addr_narrow();
    t_start();
    t_data();
    t_reserved();
    t_lock();
    t_lowpower();
    t_set_wins();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule